// File: doc/BRIEF.md
# Sensorless Motor Start-Up Mode Sequencer

This block brings a three-phase brushless motor without position sensors from standstill to closed-loop commutation. After reset, or whenever the stop input is raised, it holds the downstream six-step commutation sequencer in its reset state. That reset state pins the rotor at a known angle for a programmed number of clock cycles.

It then runs an open-loop ramp. A period counter emits commutation strobes. The gap between strobes starts at a programmed value and shrinks by a programmed decrement after every strobe, down to a programmed floor. During this phase the back-EMF sampler is kept disabled, and the external phase-locked loop's strobe input is ignored. Once the programmed ramp time has elapsed, the block waits for its next own strobe. It issues that strobe and, in the same cycle, switches to run mode. From then on it forwards the loop's strobes and enables the sampler. Because the switch happens only on a strobe boundary, a step is never doubled or lost at the handover.

Top module: `startup_seq`

## Requirements
- R1: While `rst_n` is low, `mode_o` is 00, `seq_hold` is 1, `bemf_en` is 0 and `step_o` is 0.
- R2: After reset release or stop release, `mode_o` stays 00 (align) for max(`align_len`,1) cycles, counting the release cycle. It then becomes 01 (ramp) and `seq_hold` drops to 0. The value 11 never appears.
- R3: Counting the first ramp cycle as cycle 0, the first ramp strobe on `step_o` appears in cycle G0 = max(`per_start`, F). Each later gap is Gn = max(Gn-1 − `per_step`, F), where F = max(`per_floor`, 1).
- R4: Once the gap reaches F it stays at F, including the case `per_floor` = 0, where strobes come every cycle.
- R5: In align and ramp, `bemf_en` is 0 and `pll_tick` has no effect on `step_o` or `mode_o`. In align, `step_o` stays 0.
- R6: The ramp ends on the first ramp strobe whose cycle index is at or beyond `ramp_len`. That strobe is still emitted, and in the same cycle `mode_o` becomes 10 and `bemf_en` becomes 1.
- R7: In run mode, `step_o` equals the value `pll_tick` had one cycle earlier, and `mode_o` stays 10.
- R8: A high `halt` forces align on the next edge from any mode: `mode_o` 00, `step_o` 0, `seq_hold` 1. All timers restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| halt | input | 1 | Stop / undervoltage request, synchronous |
| align_len | input | CNT_W | Align duration in cycles |
| ramp_len | input | CNT_W | Minimum ramp duration in cycles |
| per_start | input | PER_W | Initial strobe gap in cycles |
| per_step | input | PER_W | Gap decrement per strobe |
| per_floor | input | PER_W | Smallest gap |
| pll_tick | input | 1 | Strobe from the phase-locked loop |
| step_o | output | 1 | Commutation strobe to the sequencer |
| seq_hold | output | 1 | Holds the commutation sequencer in reset |
| mode_o | output | 2 | 00 align, 01 ramp, 10 run |
| bemf_en | output | 1 | Back-EMF sampler enable |

## Verification
The hardest situation to reach is the handover, because its timing depends on where the strobe grid falls relative to the end of the ramp time. The stimulus picks gap profiles for which the final ramp strobe lands exactly on `ramp_len` and, separately, where it lands after it. A zero ramp time and a zero floor are also covered. The bench computes the strobe schedule itself and toggles `pll_tick` throughout align and ramp to show it is ignored. Stop is then raised mid-ramp and in run mode to prove the restart.

// File: rtl/startup_seq.sv
module startup_seq #(
  parameter int CNT_W = 24,
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt,
  input  logic [CNT_W-1:0] align_len,
  input  logic [CNT_W-1:0] ramp_len,
  input  logic [PER_W-1:0] per_start,
  input  logic [PER_W-1:0] per_step,
  input  logic [PER_W-1:0] per_floor,
  input  logic             pll_tick,
  output logic             step_o,
  output logic             seq_hold,
  output logic [1:0]       mode_o,
  output logic             bemf_en
);
  localparam logic [1:0] M_ALIGN = 2'b00;
  localparam logic [1:0] M_RAMP  = 2'b01;
  localparam logic [1:0] M_RUN   = 2'b10;

  logic [1:0]       mode_q;
  logic [CNT_W-1:0] tmr_q;
  logic             done_q;
  logic [PER_W-1:0] ph_q;
  logic [PER_W-1:0] per_q;
  logic             step_q;

  logic [PER_W-1:0] floor_eff, start_eff, per_next;
  logic [CNT_W:0]   tmr_inc;
  logic             align_end, ramp_exp, strobe;

  assign floor_eff = (per_floor == '0) ? PER_W'(1) : per_floor;
  assign start_eff = (per_start > floor_eff) ? per_start : floor_eff;
  assign tmr_inc   = {1'b0, tmr_q} + (CNT_W+1)'(1);
  assign align_end = tmr_inc >= {1'b0, align_len};
  assign ramp_exp  = done_q | (tmr_inc >= {1'b0, ramp_len});
  assign strobe    = ({1'b0, ph_q} + (PER_W+1)'(1)) >= {1'b0, per_q};
  assign per_next  = ({1'b0, per_q} > ({1'b0, floor_eff} + {1'b0, per_step}))
                     ? per_q - per_step : floor_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_ALIGN;
      tmr_q  <= '0;
      done_q <= 1'b0;
      ph_q   <= '0;
      per_q  <= '0;
      step_q <= 1'b0;
    end else if (halt) begin
      mode_q <= M_ALIGN;
      tmr_q  <= '0;
      done_q <= 1'b0;
      ph_q   <= '0;
      per_q  <= '0;
      step_q <= 1'b0;
    end else begin
      case (mode_q)
        M_ALIGN: begin
          step_q <= 1'b0;
          if (align_end) begin
            mode_q <= M_RAMP;
            tmr_q  <= '0;
            ph_q   <= '0;
            per_q  <= start_eff;
          end else begin
            tmr_q <= tmr_q + CNT_W'(1);
          end
        end
        M_RAMP: begin
          if (!done_q) begin
            tmr_q <= tmr_q + CNT_W'(1);
            if (ramp_exp) done_q <= 1'b1;
          end
          step_q <= strobe;
          if (strobe) begin
            ph_q  <= '0;
            per_q <= per_next;
            if (ramp_exp) mode_q <= M_RUN;
          end else begin
            ph_q <= ph_q + PER_W'(1);
          end
        end
        M_RUN:   step_q <= pll_tick;
        default: mode_q <= M_ALIGN;
      endcase
    end
  end

  assign step_o   = step_q;
  assign mode_o   = mode_q;
  assign seq_hold = (mode_q == M_ALIGN);
  assign bemf_en  = (mode_q == M_RUN);
endmodule

// File: rtl/startup_seq_chk.sv
module startup_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       halt,
  input logic       pll_tick,
  input logic       step_o,
  input logic [1:0] mode_o
);
  p_no_code3_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o != 2'b11);

  p_align_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b00) |-> !step_o);

  p_align_no_skip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b00 && !halt) |=> (mode_o != 2'b10));

  p_run_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b10 && !halt) |=> (mode_o == 2'b10));

  p_handover_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b10 && $past(mode_o) == 2'b01) |-> step_o);

  p_run_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b10 && $past(mode_o) == 2'b10 && !$past(halt))
      |-> (step_o == $past(pll_tick)));

  p_halt_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (mode_o == 2'b00 && !step_o));
endmodule

bind startup_seq startup_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .halt(halt), .pll_tick(pll_tick),
  .step_o(step_o), .mode_o(mode_o)
);

// File: tb/startup_seq_tb_top.sv
module startup_seq_tb_top;
  localparam int CW = 24;
  localparam int PW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt = 1'b0;
  logic [CW-1:0] align_len = '0, ramp_len = '0;
  logic [PW-1:0] per_start = '0, per_step = '0, per_floor = '0;
  logic pll_tick = 1'b0;
  logic step_o, seq_hold, bemf_en;
  logic [1:0] mode_o;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  startup_seq #(.CNT_W(CW), .PER_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .halt(halt),
    .align_len(align_len), .ramp_len(ramp_len),
    .per_start(per_start), .per_step(per_step), .per_floor(per_floor),
    .pll_tick(pll_tick), .step_o(step_o), .seq_hold(seq_hold),
    .mode_o(mode_o), .bemf_en(bemf_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(mode_o == 2'b00, "R1 mode", mode_o, 0);
    chk(seq_hold == 1'b1, "R1 hold", seq_hold, 1);
    chk(bemf_en == 1'b0, "R1 bemf", bemf_en, 0);
    chk(step_o == 1'b0, "R1 step", step_o, 0);
  endtask

  task automatic restart();
    halt = 1'b1;
    @(negedge clk);
    chk(mode_o == 2'b00 && seq_hold, "R8 mode/hold after halt", mode_o, 0);
    chk(step_o == 1'b0, "R8 step after halt", step_o, 0);
    halt = 1'b0;
  endtask

  task automatic t_profile(input int a, input int r, input int p0,
                           input int d, input int f);
    int fe, ge, n, k, nxt, p, t, q, h, badstep, badb;
    align_len = CW'(a); ramp_len = CW'(r);
    per_start = PW'(p0); per_step = PW'(d); per_floor = PW'(f);
    restart();
    fe = (f == 0) ? 1 : f;
    ge = (p0 > fe) ? p0 : fe;
    n = 0; badb = 0;
    while (mode_o == 2'b00 && n < 5000) begin
      if (step_o || bemf_en) badb++;
      n++;
      pll_tick = n[0];
      @(negedge clk);
    end
    chk(n == ((a == 0) ? 1 : a), "R2 align length", n, (a == 0) ? 1 : a);
    chk(mode_o == 2'b01 && !seq_hold, "R2 enter ramp, hold low", mode_o, 1);
    chk(badb == 0, "R5 quiet align despite pll_tick", badb, 0);
    t = ge; q = ge;
    while (t < r) begin
      q = (q - d < fe) ? fe : q - d;
      t += q;
    end
    h = t;
    k = 0; nxt = ge; p = ge; badstep = 0; badb = 0;
    while (mode_o == 2'b01 && k < 50000) begin
      if (step_o !== (k == nxt)) badstep++;
      if (bemf_en) badb++;
      if (k == nxt) begin
        p = (p - d < fe) ? fe : p - d;
        nxt += p;
      end
      k++;
      pll_tick = ~pll_tick;
      @(negedge clk);
    end
    pll_tick = 1'b0;
    chk(badstep == 0, "R3 R4 ramp strobe schedule", badstep, 0);
    chk(badb == 0, "R5 sampler off in ramp", badb, 0);
    chk(k == h, "R6 handover cycle", k, h);
    chk(mode_o == 2'b10 && bemf_en, "R6 run mode and sampler on", mode_o, 2);
    chk(step_o == 1'b1, "R6 handover strobe emitted", step_o, 1);
  endtask

  task automatic t_run();
    bit [7:0] pat = 8'b1011_0010;
    for (int i = 0; i < 8; i++) begin
      pll_tick = pat[i];
      @(negedge clk);
      chk(step_o == pat[i] && mode_o == 2'b10, "R7 follow pll_tick", step_o, pat[i]);
    end
    pll_tick = 1'b0;
  endtask

  task automatic t_halt_ramp();
    align_len = CW'(3); ramp_len = CW'(500);
    per_start = PW'(9); per_step = PW'(1); per_floor = PW'(4);
    restart();
    while (mode_o != 2'b01) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(mode_o == 2'b01, "R8 in ramp before halt", mode_o, 1);
    restart();
    chk(mode_o == 2'b00, "R8 align after mid-ramp halt", mode_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_profile(5, 40, 10, 2, 3);
    t_run();
    t_profile(0, 0, 4, 1, 0);
    t_run();
    t_halt_ramp();
    t_profile(7, 25, 6, 0, 2);
    t_run();
    t_profile(2, 13, 20, 5, 3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule